// File: doc/BRIEF.md
# Multicast APB slave-select decoder

This decoder sits on an APB-style bus behind a bridge. It takes a small group of upper address bits and treats each bit as the select of one slave. The address space is cut into as many equal areas as there are slaves. A write can set several of these bits, which makes it reach several slaves in one transfer. This gives multicast, or broadcast when every bit is set. The address bits below the selector group go unchanged to every selected slave, so each slave decodes its own registers.

Reads must name exactly one slave. A read that sets more than one selector bit is answered by the decoder itself with an error, and no slave is selected. When the selector group is all zero, the access goes to a default region, which has its own port. The bits above the selector group must equal the configured base. If they do not, the decoder selects nothing and answers with an error. For a multicast transfer, the decoder remembers which slaves have already finished. A slave's select drops once that slave has finished, and the bus sees ready only when every selected slave has finished. The error response is the OR of the errors those slaves raised during the transfer.

Top module: `mcast_apb_decoder`

## Requirements
- R1: While reset is asserted and right after it is released, no slave select, default select, ready or error output is high.
- R2: With exactly one selector bit set (selector bits are address bits SEL_LSB to SEL_LSB+N_SLV-1, bit SEL_LSB selecting slave 0), only that slave's select is high and the low SEL_LSB address bits appear unchanged on the forwarded address.
- R3: A write with several selector bits set raises the select of every matching slave in the same cycle.
- R4: A write with all selector bits set raises every slave select and writes each slave exactly once.
- R5: A read with more than one selector bit set selects nothing and completes in its first access cycle with ready and error both high.
- R6: When every selector bit is zero and the upper bits match, only the default region select is raised, for reads and writes.
- R7: When the address bits above the selector group differ from BASE_ADDR, nothing is selected and the transfer completes in its first access cycle with an error.
- R8: A multicast transfer completes only in the cycle in which the last selected slave is ready. A slave that has been ready loses its select in the next cycle, so each slave completes once.
- R9: The error response at completion is high if any selected target raised its error together with its ready at any point of the transfer.
- R10: Read data at completion comes from the single selected target, and it is zero when the decoder itself answers with an error.
- R11: Ready and error stay low outside the access phase (select and enable both high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Upstream select |
| penable | input | 1 | Upstream access phase |
| pwrite | input | 1 | Upstream direction, 1 = write |
| paddr | input | ADDR_W | Upstream address |
| pwdata | input | DATA_W | Upstream write data |
| prdata | output | DATA_W | Read data returned upstream |
| pready | output | 1 | Transfer complete |
| pslverr | output | 1 | Transfer error |
| m_sel | output | N_SLV | Per-slave select, one bit per selector bit |
| m_enable | output | 1 | Access phase forwarded to slaves |
| m_write | output | 1 | Direction forwarded to slaves |
| m_addr | output | SEL_LSB | In-slave address |
| m_wdata | output | DATA_W | Write data forwarded to slaves |
| m_rdata | input | N_SLV*DATA_W | Read data of slave i in bits i*DATA_W upward |
| m_ready | input | N_SLV | Per-slave ready |
| m_err | input | N_SLV | Per-slave error |
| d_sel | output | 1 | Default region select |
| d_rdata | input | DATA_W | Default region read data |
| d_ready | input | 1 | Default region ready |
| d_err | input | 1 | Default region error |

## Verification
The selector field is driven with one bit, two bits, all bits and no bits, both as writes and as reads. This separates plain routing, fan-out, the local multi-read error and the default fallback. The slaves answer with different wait-state counts, so a decoder that completes on the first ready is told apart from one that waits for the last, and per-slave completion counts expose repeated writes. Errors are placed on the slave that finishes first, which tests that errors are accumulated and not just sampled at the end. Addresses outside the base show that unclaimed transfers are refused.

// File: rtl/mcd_pkg.sv
`timescale 1ns/1ps
package mcd_pkg;
   // Classification of the current upstream request
   typedef enum logic [1:0] {
      XF_IDLE     = 2'd0,
      XF_ROUTE    = 2'd1,
      XF_MULTIRD  = 2'd2,
      XF_UNMAPPED = 2'd3
   } xfer_kind_e;

   function automatic logic is_fault(xfer_kind_e k);
      return (k == XF_MULTIRD) || (k == XF_UNMAPPED);
   endfunction
endpackage

// File: rtl/mcd_addr_split.sv
`timescale 1ns/1ps
module mcd_addr_split #(
   parameter int ADDR_W  = 32,
   parameter int N_SLV   = 3,
   parameter int SEL_LSB = 13,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2123_0000
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic               in_base,
   output logic [N_SLV-1:0]   field,
   output logic [SEL_LSB-1:0] loc_addr
);
   localparam int UP_LSB = SEL_LSB + N_SLV;
   localparam int UP_W   = ADDR_W - UP_LSB;

   logic [UP_W-1:0] up_eq;

   // bitwise compare of the region bits against the base
   for (genvar b = 0; b < UP_W; b++) begin : g_up
      assign up_eq[b] = (addr[UP_LSB+b] == BASE_ADDR[UP_LSB+b]);
   end

   assign in_base  = &up_eq;
   assign field    = addr[SEL_LSB +: N_SLV];
   assign loc_addr = addr[SEL_LSB-1:0];
endmodule

// File: rtl/mcd_tgt_gen.sv
`timescale 1ns/1ps
module mcd_tgt_gen
   import mcd_pkg::*;
#(
   parameter int N_SLV = 3
) (
   input  logic             req,
   input  logic             wr,
   input  logic             in_base,
   input  logic [N_SLV-1:0] field,
   output logic [N_SLV:0]   tgt,
   output xfer_kind_e       kind
);
   logic multi;
   assign multi = ($countones(field) > 1);

   always_comb begin
      tgt  = '0;
      kind = XF_IDLE;
      if (req) begin
         if (!in_base) begin
            kind = XF_UNMAPPED;
         end else if (!wr && multi) begin
            kind = XF_MULTIRD;
         end else begin
            kind = XF_ROUTE;
            if (field == '0) tgt[N_SLV] = 1'b1;
            else             tgt[N_SLV-1:0] = field;
         end
      end
   end
endmodule

// File: rtl/mcd_resp_merge.sv
`timescale 1ns/1ps
module mcd_resp_merge #(
   parameter int N_TGT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             fault,
   input  logic [N_TGT-1:0] tgt,
   input  logic [N_TGT-1:0] rdy,
   input  logic [N_TGT-1:0] err,
   output logic [N_TGT-1:0] grant,
   output logic             complete,
   output logic             err_out
);
   logic [N_TGT-1:0] done_q, done_d, fin, pend;
   logic             eacc_q, eacc_d, err_now;

   assign grant    = tgt & ~done_q;
   assign fin      = {N_TGT{active}} & grant & rdy;
   assign pend     = grant & ~rdy;
   assign err_now  = |(fin & err);
   assign complete = active & (fault | ((|tgt) & ~(|pend)));
   assign err_out  = complete & (fault | eacc_q | err_now);

   always_comb begin
      if (!active || complete) begin
         done_d = '0;
         eacc_d = 1'b0;
      end else begin
         done_d = done_q | fin;
         eacc_d = eacc_q | err_now;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= '0;
         eacc_q <= 1'b0;
      end else begin
         done_q <= done_d;
         eacc_q <= eacc_d;
      end
   end
endmodule

// File: rtl/mcast_apb_decoder.sv
`timescale 1ns/1ps
module mcast_apb_decoder
   import mcd_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int N_SLV   = 3,
   parameter int SEL_LSB = 13,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2123_0000
) (
   input  logic                    pclk,
   input  logic                    presetn,
   input  logic                    psel,
   input  logic                    penable,
   input  logic                    pwrite,
   input  logic [ADDR_W-1:0]       paddr,
   input  logic [DATA_W-1:0]       pwdata,
   output logic [DATA_W-1:0]       prdata,
   output logic                    pready,
   output logic                    pslverr,
   output logic [N_SLV-1:0]        m_sel,
   output logic                    m_enable,
   output logic                    m_write,
   output logic [SEL_LSB-1:0]      m_addr,
   output logic [DATA_W-1:0]       m_wdata,
   input  logic [N_SLV*DATA_W-1:0] m_rdata,
   input  logic [N_SLV-1:0]        m_ready,
   input  logic [N_SLV-1:0]        m_err,
   output logic                    d_sel,
   input  logic [DATA_W-1:0]       d_rdata,
   input  logic                    d_ready,
   input  logic                    d_err
);
   localparam int N_TGT  = N_SLV + 1;
   localparam int UP_LSB = SEL_LSB + N_SLV;

   if (N_SLV < 1) begin : g_bad_n
      $error("N_SLV must be at least 1");
   end
   if (SEL_LSB < 1 || UP_LSB >= ADDR_W) begin : g_bad_pos
      $error("selector group must leave room below and above it");
   end
   if (BASE_ADDR[UP_LSB-1:0] != '0) begin : g_bad_base
      $error("BASE_ADDR must be aligned to the selector group");
   end

   logic               in_base, active, fault;
   logic [N_SLV-1:0]   field;
   logic [N_TGT-1:0]   tgt, grant, rdy, err;
   xfer_kind_e         kind;
   logic [DATA_W-1:0]  tdata [N_TGT];

   mcd_addr_split #(
      .ADDR_W(ADDR_W), .N_SLV(N_SLV), .SEL_LSB(SEL_LSB), .BASE_ADDR(BASE_ADDR)
   ) u_split (
      .addr(paddr), .in_base(in_base), .field(field), .loc_addr(m_addr)
   );

   mcd_tgt_gen #(.N_SLV(N_SLV)) u_tgt (
      .req(psel), .wr(pwrite), .in_base(in_base), .field(field),
      .tgt(tgt), .kind(kind)
   );

   assign active = psel & penable;
   assign fault  = is_fault(kind);
   assign rdy    = {d_ready, m_ready};
   assign err    = {d_err, m_err};

   mcd_resp_merge #(.N_TGT(N_TGT)) u_merge (
      .clk(pclk), .rst_n(presetn), .active(active), .fault(fault),
      .tgt(tgt), .rdy(rdy), .err(err),
      .grant(grant), .complete(pready), .err_out(pslverr)
   );

   assign m_sel    = grant[N_SLV-1:0];
   assign d_sel    = grant[N_SLV];
   assign m_enable = penable;
   assign m_write  = pwrite;
   assign m_wdata  = pwdata;

   for (genvar i = 0; i < N_SLV; i++) begin : g_rd
      assign tdata[i] = m_rdata[i*DATA_W +: DATA_W];
   end
   assign tdata[N_SLV] = d_rdata;

   always_comb begin
      prdata = '0;
      for (int t = 0; t < N_TGT; t++) begin
         if (tgt[t]) prdata = prdata | tdata[t];
      end
   end
endmodule

// File: rtl/mcd_apb_checker.sv
`timescale 1ns/1ps
module mcd_apb_checker #(
   parameter int ADDR_W  = 32,
   parameter int N_SLV   = 3,
   parameter int SEL_LSB = 13,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h2123_0000
) (
   input logic              pclk,
   input logic              presetn,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic              pready,
   input logic              pslverr,
   input logic [N_SLV-1:0]  m_sel,
   input logic [N_SLV-1:0]  m_ready,
   input logic              d_sel
);
   localparam int UP_LSB = SEL_LSB + N_SLV;

   logic             hit;
   logic [N_SLV-1:0] fld;
   assign hit = (paddr[ADDR_W-1:UP_LSB] == BASE_ADDR[ADDR_W-1:UP_LSB]);
   assign fld = paddr[SEL_LSB +: N_SLV];

   // R7
   nomatch_nosel_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !hit) |-> (m_sel == '0 && !d_sel && (!penable || (pready && pslverr))));

   // R5
   multird_err_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && penable && !pwrite && hit && $countones(fld) > 1)
         |-> (pready && pslverr && m_sel == '0 && !d_sel));

   // R6
   dflt_excl_chk: assert property (@(posedge pclk) disable iff (!presetn)
      d_sel |-> (m_sel == '0));

   // R11
   idle_nordy_chk: assert property (@(posedge pclk) disable iff (!presetn)
      !(psel && penable) |-> (!pready && !pslverr));

   // R2
   rd_single_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !pwrite) |-> $onehot0({d_sel, m_sel}));

   // R3
   wr_fanout_chk: assert property (@(posedge pclk) disable iff (!presetn)
      (psel && !penable && pwrite && hit && fld != '0) |-> (m_sel == fld));

   for (genvar i = 0; i < N_SLV; i++) begin : g_drop
      // R8
      sel_drop_chk: assert property (@(posedge pclk) disable iff (!presetn)
         (m_sel[i] && penable && m_ready[i] && !pready) |=> !m_sel[i]);
   end
endmodule

bind mcast_apb_decoder mcd_apb_checker #(
   .ADDR_W(ADDR_W), .N_SLV(N_SLV), .SEL_LSB(SEL_LSB), .BASE_ADDR(BASE_ADDR)
) u_chk (
   .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
   .pwrite(pwrite), .paddr(paddr), .pready(pready), .pslverr(pslverr),
   .m_sel(m_sel), .m_ready(m_ready), .d_sel(d_sel)
);

// File: tb/test_mcast_apb_decoder.sv
`timescale 1ns/1ps
module test_mcast_apb_decoder;
   localparam int AW = 32, DW = 32, NS = 3, SL = 13;
   localparam logic [31:0] BASE = 32'h2123_0000;
   localparam int NT = NS + 1;

   logic clk = 0, presetn = 0;
   logic psel = 0, penable = 0, pwrite = 0;
   logic [AW-1:0] paddr = '0;
   logic [DW-1:0] pwdata = '0, prdata, d_rdata;
   logic pready, pslverr, m_enable, m_write, d_sel, d_ready, d_err;
   logic [NS-1:0] m_sel, m_ready, m_err;
   logic [SL-1:0] m_addr;
   logic [DW-1:0] m_wdata;
   logic [NS*DW-1:0] m_rdata;

   always #2 clk = ~clk;

   mcast_apb_decoder #(.ADDR_W(AW), .DATA_W(DW), .N_SLV(NS), .SEL_LSB(SL),
      .BASE_ADDR(BASE)) i_mcast_apb_decoder (
      .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .m_sel(m_sel), .m_enable(m_enable),
      .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
      .m_ready(m_ready), .m_err(m_err), .d_sel(d_sel), .d_rdata(d_rdata),
      .d_ready(d_ready), .d_err(d_err));

   int checks = 0, fails = 0;
   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // ---------------- behavioural slaves ----------------
   int lat [NT];
   int cnt [NT];
   int wcnt [NT];
   logic [NT-1:0] erv, gnt, rdy_v;
   function automatic logic [DW-1:0] tdat(int t);
      return 32'h5A00_0000 | t;
   endfunction
   assign gnt = {d_sel, m_sel};
   always_comb
      for (int t = 0; t < NT; t++) rdy_v[t] = gnt[t] && penable && (cnt[t] == lat[t]);
   assign m_ready = rdy_v[NS-1:0];
   assign d_ready = rdy_v[NS];
   assign m_err   = erv[NS-1:0];
   assign d_err   = erv[NS];
   assign d_rdata = tdat(NS);
   always_comb
      for (int t = 0; t < NS; t++) m_rdata[t*DW +: DW] = tdat(t);

   always @(posedge clk)
      for (int t = 0; t < NT; t++) begin
         if (gnt[t] && penable) begin
            if (rdy_v[t]) begin
               cnt[t] <= 0;
               if (pwrite) wcnt[t] <= wcnt[t] + 1;
            end else cnt[t] <= cnt[t] + 1;
         end else cnt[t] <= 0;
      end

   // ---------------- reference model ----------------
   int  m_done = 0;
   bit  m_eacc = 0;
   int  e_fin = 0;
   bit  e_rdy = 0, e_err = 0;
   string cur_req = "R1";
   always @(negedge clk) begin
      if (presetn) begin
         int fld, ones, tg, gn, fin;
         bit hit, flt, acc, pend;
         hit  = (paddr >> (SL + NS)) == (BASE >> (SL + NS));
         fld  = (paddr >> SL) & ((1 << NS) - 1);
         ones = 0;
         for (int b = 0; b < NS; b++) if (fld[b]) ones++;
         flt = psel && (!hit || (!pwrite && ones > 1));
         tg  = 0;
         if (psel && !flt) tg = (fld == 0) ? (1 << NS) : fld;
         gn  = tg & ~m_done;
         acc = psel && penable;
         pend = 0; fin = 0;
         for (int t = 0; t < NT; t++)
            if (gn[t]) begin
               if (rdy_v[t]) fin |= (1 << t); else pend = 1;
            end
         if (!acc) fin = 0;
         e_rdy = acc && (flt || (tg != 0 && !pend));
         e_err = e_rdy && (flt || m_eacc || ((fin & erv) != 0));
         e_fin = fin;
         chk(m_sel == gn[NS-1:0], cur_req, "m_sel", m_sel, gn[NS-1:0]);
         chk(d_sel == gn[NS], cur_req, "d_sel", d_sel, gn[NS]);
         chk(pready == e_rdy, cur_req, "pready", pready, e_rdy);
         chk(pslverr == e_err, cur_req, "pslverr", pslverr, e_err);
         if (psel) chk(m_addr == paddr[SL-1:0], "R2", "m_addr", m_addr, paddr[SL-1:0]);
         if (e_rdy && !pwrite) begin
            logic [DW-1:0] er;
            er = '0;
            for (int t = 0; t < NT; t++) if (tg[t]) er = tdat(t);
            chk(prdata == er, "R10", "prdata", prdata, er);
         end
      end
   end
   always @(posedge clk or negedge presetn) begin
      if (!presetn) begin m_done <= 0; m_eacc <= 0; end
      else if (!(psel && penable) || e_rdy) begin m_done <= 0; m_eacc <= 0; end
      else begin
         m_done <= m_done | e_fin;
         m_eacc <= m_eacc || ((e_fin & erv) != 0);
      end
   end

   // ---------------- directed transfers ----------------
   task automatic xfer(input logic [31:0] a, input bit wr, output bit er,
                       output logic [DW-1:0] rd, output int cyc);
      @(posedge clk); #1;
      psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = a ^ 32'hFFFF;
      @(posedge clk); #1;
      penable = 1;
      cyc = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (pready || cyc > 50) break;
      end
      er = pslverr; rd = prdata;
      @(posedge clk); #1;
      psel = 0; penable = 0;
   endtask

   task automatic run(string req, logic [31:0] a, bit wr, bit xer, int xcyc,
                      logic [NT-1:0] xw, logic [DW-1:0] xrd);
      bit er; logic [DW-1:0] rd; int cyc; int w0 [NT];
      cur_req = req;
      for (int t = 0; t < NT; t++) w0[t] = wcnt[t];
      xfer(a, wr, er, rd, cyc);
      chk(er == xer, req, "error response", er, xer);
      chk(cyc == xcyc, req, "access cycles", cyc, xcyc);
      for (int t = 0; t < NT; t++)
         chk(wcnt[t] - w0[t] == int'(xw[t]), req, $sformatf("writes on target %0d", t),
             wcnt[t] - w0[t], xw[t]);
      if (!wr) chk(rd == xrd, req, "read data", rd, xrd);
      @(negedge clk);
      chk(!pready && !pslverr, "R11", "idle ready/error", {pready, pslverr}, 0);
   endtask

   function automatic logic [31:0] adr(int f, int off);
      return BASE | (f << SL) | off;
   endfunction

   initial begin
      for (int t = 0; t < NT; t++) begin lat[t] = 0; cnt[t] = 0; wcnt[t] = 0; end
      erv = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(m_sel == 0 && !d_sel && !pready && !pslverr, "R1", "outputs in reset",
          {m_sel, d_sel, pready, pslverr}, 0);
      presetn = 1;
      @(negedge clk);
      chk(m_sel == 0 && !d_sel && !pready && !pslverr, "R1", "outputs after reset",
          {m_sel, d_sel, pready, pslverr}, 0);

      lat[1] = 1;
      run("R2", adr(2, 13'h124), 1, 0, 2, 4'b0010, '0);
      lat[2] = 2;
      run("R10", adr(4, 13'h008), 0, 0, 3, 4'b0000, tdat(2));
      lat[0] = 3; lat[1] = 0; lat[2] = 0;
      run("R3", adr(3, 13'h040), 1, 0, 4, 4'b0011, '0);
      cur_req = "R8";
      run("R8", adr(5, 13'h1FF), 1, 0, 4, 4'b0101, '0);
      lat[0] = 1; lat[1] = 2; lat[2] = 0; erv = 4'b0100;
      run("R4", adr(7, 13'h010), 1, 1, 3, 4'b0111, '0);
      run("R9", adr(6, 13'h020), 1, 1, 3, 4'b0110, '0);
      erv = 4'b0001; lat[0] = 0;
      run("R9", adr(1, 13'h004), 0, 1, 1, 4'b0000, tdat(0));
      erv = '0;
      run("R5", adr(5, 13'h004), 0, 1, 1, 4'b0000, '0);
      run("R5", adr(7, 13'h004), 0, 1, 1, 4'b0000, '0);
      lat[3] = 1;
      run("R6", adr(0, 13'h1F0), 1, 0, 2, 4'b1000, '0);
      run("R6", adr(0, 13'h0F0), 0, 0, 2, 4'b0000, tdat(3));
      run("R7", 32'h2124_2000, 1, 1, 1, 4'b0000, '0);
      run("R7", 32'h0000_0000, 0, 1, 1, 4'b0000, '0);
      run("R7", 32'hA123_E000, 1, 1, 1, 4'b0000, '0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #400000;
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule